// File: doc/BRIEF.md
# Serial EEPROM Two-Wire Slave Engine

This block is the bus side of a 128-byte serial EEPROM that acts as a slave on an I2C bus. It runs on a fast system clock. The SCL and SDA lines pass through a two-stage synchronizer, and the engine detects START and STOP conditions and SCL edges from the synchronized samples. It shifts in a device select byte and compares it with a fixed device code and three strap inputs. It answers with acknowledge bits through an open-drain style pull-down enable. The engine keeps a 7-bit address pointer between transactions and serves three kinds of read: current-address reads from that pointer, random reads set up by a write-direction select and an address byte followed by a repeated START, and sequential reads of any length.

Each data byte the master writes is handed to an external write controller as a one-cycle strobe with address and data. A STOP that closes a write which carried data raises a one-cycle commit pulse so that the controller can start its programming cycle. While that controller reports a busy programming cycle, the engine ignores START conditions and stays off the bus. The storage array sits outside the engine and is reached through a synchronous read port with one cycle of latency.

Top module: `ee_i2c_slave`

## Requirements
- R1: The device select byte is received MSB first as 1,0,1,0, then strap[2], strap[1], strap[0], then the direction bit (1 = read). When it matches, the engine pulls SDA low for the whole 9th SCL clock, and it never drives SDA while it is receiving bits 1 to 8 of a byte.
- R2: When the select byte does not match the straps, SDA stays released during the 9th clock. Later bytes cause no acknowledge, no write strobe and no read until the next START.
- R3: A START (SDA falling while SCL is high) restarts select reception from any state, including a repeated START in the middle of a transfer. A STOP (SDA rising while SCL is high) returns the engine to standby.
- R4: After reset SDA is released. The engine changes its SDA drive only while SCL is low, and it samples incoming data on the rising edge of SCL.
- R5: In a write, the first byte after the select loads the pointer from its low 7 bits; bit 7 is ignored. Each later byte is acknowledged, presented as a one-cycle write strobe with the current pointer and the byte, and the pointer then increments.
- R6: A STOP after at least one data byte has been written gives exactly one single-cycle commit pulse. A STOP after a write that carried only an address byte gives none.
- R7: A read-direction select with no preceding address returns the byte at the retained pointer, which is the location after the last byte written or read.
- R8: A write-direction select and an address byte, followed by a repeated START and a read-direction select, return the byte stored at that address.
- R9: While the master acknowledges, reads continue from consecutive addresses. The pointer advances once per byte sent and wraps from 127 to 0.
- R10: After a master no-acknowledge the engine releases SDA and sends nothing on further clocks. The following STOP puts it back in standby.
- R11: A START that arrives while prog_busy is high is ignored, and the engine gives no acknowledge until a START arrives with prog_busy low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen at the pin |
| sda_in | input | 1 | Bus data line as seen at the pin (wired level) |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| strap | input | 3 | Address strap inputs compared with select bits 3..1 |
| prog_busy | input | 1 | High while the write controller runs a programming cycle |
| rd_en | output | 1 | One-cycle read request to the storage array |
| rd_addr | output | 7 | Address of the read request |
| rd_data | input | 8 | Array data, valid from the cycle after rd_en |
| wr_en | output | 1 | One-cycle strobe for a received write byte |
| wr_addr | output | 7 | Address for the received write byte |
| wr_data | output | 8 | Received write byte |
| wr_commit | output | 1 | One-cycle pulse on a STOP that closes a write with data |

## Verification
Two events can fall in the same system clock cycle: the synchronized START and a change of prog_busy. The bench raises prog_busy before a START, clocks a full select byte, and requires the 9th clock to read high on the wired line. It then lowers prog_busy and checks that the next START is acknowledged. A bound property also requires that a START seen with prog_busy high leaves the engine in standby on the next cycle. A second overlap is a STOP that arrives at the point where the last written byte completes. The bench counts commit pulses across STOPs that follow address-only writes and STOPs that follow writes with data.

// File: rtl/ee_pkg.sv
package ee_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_DEVSEL = 3'd1,
        ST_ADDR   = 3'd2,
        ST_WDATA  = 3'd3,
        ST_ACK    = 3'd4,
        ST_TX     = 3'd5,
        ST_MACK   = 3'd6
    } state_e;

    typedef enum logic [1:0] {
        AF_TX    = 2'd0,
        AF_ADDR  = 2'd1,
        AF_WDATA = 2'd2
    } after_e;

endpackage

// File: rtl/ee_line_sync.sv
module ee_line_sync #(
    parameter int LINES  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw,
    output logic [LINES-1:0] cur,
    output logic [LINES-1:0] prev
);
    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES:0] chain_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= {chain_q[STAGES-1:0], raw[g]};
        end
        assign cur[g]  = chain_q[STAGES-1];
        assign prev[g] = chain_q[STAGES];
    end
endmodule

// File: rtl/ee_cond_detect.sv
module ee_cond_detect (
    input  logic scl_cur,
    input  logic scl_prev,
    input  logic sda_cur,
    input  logic sda_prev,
    output logic start_det,
    output logic stop_det,
    output logic scl_rise,
    output logic scl_fall
);
    logic scl_high;
    assign scl_high  = scl_cur & scl_prev;
    assign start_det = scl_high & sda_prev & ~sda_cur;
    assign stop_det  = scl_high & ~sda_prev & sda_cur;
    assign scl_rise  = scl_cur & ~scl_prev;
    assign scl_fall  = ~scl_cur & scl_prev;
endmodule

// File: rtl/ee_select_match.sv
module ee_select_match #(
    parameter int         DATA_W   = 8,
    parameter int         STRAP_W  = 3,
    parameter logic [3:0] DEV_CODE = 4'b1010
) (
    input  logic [DATA_W-1:0]  sel_byte,
    input  logic [STRAP_W-1:0] strap,
    output logic               hit,
    output logic               read_dir
);
    localparam int CODE_LSB = DATA_W - 4;

    assign hit      = (sel_byte[DATA_W-1:CODE_LSB] == DEV_CODE) &&
                      (sel_byte[STRAP_W:1] == strap);
    assign read_dir = sel_byte[0];
endmodule

// File: rtl/ee_i2c_slave.sv
module ee_i2c_slave #(
    parameter int         ADDR_W      = 7,
    parameter int         DATA_W      = 8,
    parameter int         STRAP_W     = 3,
    parameter int         SYNC_STAGES = 2,
    parameter logic [3:0] DEV_CODE    = 4'b1010
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_in,
    input  logic               sda_in,
    output logic               sda_oe,
    input  logic [STRAP_W-1:0] strap,
    input  logic               prog_busy,
    output logic               rd_en,
    output logic [ADDR_W-1:0]  rd_addr,
    input  logic [DATA_W-1:0]  rd_data,
    output logic               wr_en,
    output logic [ADDR_W-1:0]  wr_addr,
    output logic [DATA_W-1:0]  wr_data,
    output logic               wr_commit
);
    import ee_pkg::*;

    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DATA_W);

    typedef struct packed {
        state_e            st;
        after_e            nxt;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] sh;
        logic [ADDR_W-1:0] ptr;
        logic              oe;
        logic              rd_en;
        logic [ADDR_W-1:0] rd_addr;
        logic              wr_en;
        logic [ADDR_W-1:0] wr_addr;
        logic [DATA_W-1:0] wr_data;
        logic              commit;
        logic              wrote;
        logic              macked;
    } regs_t;

    regs_t q, d;

    logic [1:0] line_cur, line_prev;
    logic       scl_s, sda_s, scl_p, sda_p;
    logic       start_det, stop_det, scl_rise, scl_fall;
    logic       sel_hit, sel_read;

    ee_line_sync #(.LINES(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   ({scl_in, sda_in}),
        .cur   (line_cur),
        .prev  (line_prev)
    );

    assign scl_s = line_cur[1];
    assign sda_s = line_cur[0];
    assign scl_p = line_prev[1];
    assign sda_p = line_prev[0];

    ee_cond_detect u_cond (
        .scl_cur   (scl_s),
        .scl_prev  (scl_p),
        .sda_cur   (sda_s),
        .sda_prev  (sda_p),
        .start_det (start_det),
        .stop_det  (stop_det),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall)
    );

    ee_select_match #(.DATA_W(DATA_W), .STRAP_W(STRAP_W), .DEV_CODE(DEV_CODE)) u_sel (
        .sel_byte (q.sh),
        .strap    (strap),
        .hit      (sel_hit),
        .read_dir (sel_read)
    );

    always_comb begin
        d        = q;
        d.rd_en  = 1'b0;
        d.wr_en  = 1'b0;
        d.commit = 1'b0;

        if (stop_det) begin
            d.st     = ST_IDLE;
            d.oe     = 1'b0;
            d.commit = q.wrote;
            d.wrote  = 1'b0;
        end else if (start_det) begin
            d.oe  = 1'b0;
            d.cnt = '0;
            d.st  = prog_busy ? ST_IDLE : ST_DEVSEL;
        end else begin
            unique case (q.st)
                ST_DEVSEL, ST_ADDR, ST_WDATA: begin
                    if (scl_rise) begin
                        d.sh  = {q.sh[DATA_W-2:0], sda_s};
                        d.cnt = q.cnt + 1'b1;
                    end else if (scl_fall && q.cnt == FULL) begin
                        d.cnt = '0;
                        if (q.st == ST_DEVSEL) begin
                            if (sel_hit) begin
                                d.oe = 1'b1;
                                d.st = ST_ACK;
                                if (sel_read) begin
                                    d.nxt     = AF_TX;
                                    d.rd_en   = 1'b1;
                                    d.rd_addr = q.ptr;
                                end else begin
                                    d.nxt = AF_ADDR;
                                end
                            end else begin
                                d.st = ST_IDLE;
                            end
                        end else if (q.st == ST_ADDR) begin
                            d.ptr = q.sh[ADDR_W-1:0];
                            d.oe  = 1'b1;
                            d.st  = ST_ACK;
                            d.nxt = AF_WDATA;
                        end else begin
                            d.wr_en   = 1'b1;
                            d.wr_addr = q.ptr;
                            d.wr_data = q.sh;
                            d.ptr     = q.ptr + 1'b1;
                            d.wrote   = 1'b1;
                            d.oe      = 1'b1;
                            d.st      = ST_ACK;
                            d.nxt     = AF_WDATA;
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        d.oe  = 1'b0;
                        d.cnt = '0;
                        unique case (q.nxt)
                            AF_TX: begin
                                d.sh = rd_data;
                                d.oe = ~rd_data[DATA_W-1];
                                d.st = ST_TX;
                            end
                            AF_ADDR: d.st = ST_ADDR;
                            default: d.st = ST_WDATA;
                        endcase
                    end
                end
                ST_TX: begin
                    if (scl_rise) begin
                        d.cnt = q.cnt + 1'b1;
                    end else if (scl_fall && q.cnt != '0) begin
                        if (q.cnt == FULL) begin
                            d.oe  = 1'b0;
                            d.ptr = q.ptr + 1'b1;
                            d.st  = ST_MACK;
                        end else begin
                            d.oe = ~q.sh[DATA_W-2];
                            d.sh = q.sh << 1;
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise) begin
                        d.macked = ~sda_s;
                        if (!sda_s) begin
                            d.rd_en   = 1'b1;
                            d.rd_addr = q.ptr;
                        end
                    end else if (scl_fall) begin
                        d.cnt = '0;
                        if (q.macked) begin
                            d.sh = rd_data;
                            d.oe = ~rd_data[DATA_W-1];
                            d.st = ST_TX;
                        end else begin
                            d.st = ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sda_oe    = q.oe;
    assign rd_en     = q.rd_en;
    assign rd_addr   = q.rd_addr;
    assign wr_en     = q.wr_en;
    assign wr_addr   = q.wr_addr;
    assign wr_data   = q.wr_data;
    assign wr_commit = q.commit;

endmodule

// File: rtl/ee_i2c_slave_chk.sv
module ee_i2c_slave_chk (
    input logic           clk,
    input logic           rst_n,
    input logic           scl_in,
    input logic           sda_oe,
    input logic           prog_busy,
    input logic           rd_en,
    input logic           wr_en,
    input logic           wr_commit,
    input logic           start_det,
    input ee_pkg::state_e st
);
    import ee_pkg::*;

    p_drive_scl_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_in);

    p_rx_released_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DEVSEL || st == ST_ADDR || st == ST_WDATA) |-> !sda_oe);

    p_busy_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det && prog_busy) |=> (st == ST_IDLE));

    p_commit_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |=> !wr_commit);

    p_rd_wr_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && wr_en));

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> (!sda_oe && !wr_en));
endmodule

bind ee_i2c_slave ee_i2c_slave_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_in    (scl_in),
    .sda_oe    (sda_oe),
    .prog_busy (prog_busy),
    .rd_en     (rd_en),
    .wr_en     (wr_en),
    .wr_commit (wr_commit),
    .start_det (start_det),
    .st        (q.st)
);

// File: tb/ee_i2c_slave_tb.sv
module ee_i2c_slave_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 12;
    localparam int WATCHDOG   = 190000;
    localparam logic [2:0] STRAPS = 3'b101;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       prog_busy = 1'b0;
    logic       sda_oe, rd_en, wr_en, wr_commit;
    logic [6:0] rd_addr, wr_addr;
    logic [7:0] wr_data;
    logic [7:0] rd_data_r;
    logic       sda_bus;

    int checks = 0;
    int fails  = 0;
    int commits = 0;
    int wr_strobes = 0;
    bit done = 1'b0;

    logic [7:0] store [128];
    logic [7:0] exp_mem [128];
    int         exp_ptr = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign sda_bus = m_sda & ~sda_oe;

    ee_i2c_slave u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (m_scl),
        .sda_in    (sda_bus),
        .sda_oe    (sda_oe),
        .strap     (STRAPS),
        .prog_busy (prog_busy),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data_r),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .wr_commit (wr_commit)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 128; i++) store[i] <= 8'h00;
            rd_data_r <= 8'h00;
        end else begin
            if (wr_en) store[wr_addr] <= wr_data;
            if (rd_en) rd_data_r <= store[rd_addr];
        end
    end

    always @(posedge clk) begin
        if (wr_commit) commits <= commits + 1;
        if (wr_en) wr_strobes <= wr_strobes + 1;
    end

    function automatic logic [7:0] sel_byte(input logic [2:0] s, input logic rw);
        return {4'b1010, s, rw};
    endfunction

    function automatic int wrap_addr(input int a);
        return a & 127;
    endfunction

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic bit_cyc(input logic b, output logic s);
        m_sda = b;
        wait_clk(HALF/2);
        m_scl = 1'b1;
        wait_clk(HALF/2);
        s = sda_bus;
        wait_clk(HALF/2);
        m_scl = 1'b0;
        wait_clk(HALF/2);
    endtask

    task automatic bus_start();
        m_sda = 1'b1;
        wait_clk(HALF/2);
        m_scl = 1'b1;
        wait_clk(HALF);
        m_sda = 1'b0;
        wait_clk(HALF);
        m_scl = 1'b0;
        wait_clk(HALF/2);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0;
        wait_clk(HALF/2);
        m_scl = 1'b1;
        wait_clk(HALF);
        m_sda = 1'b1;
        wait_clk(HALF);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        logic s;
        for (int i = 7; i >= 0; i--) bit_cyc(b[i], s);
        bit_cyc(1'b1, s);
        acked = ~s;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bit_cyc(1'b1, s);
            b[i] = s;
        end
        bit_cyc(~give_ack, s);
    endtask

    task automatic write_seq(input int addr, input int n, input bit random_data);
        logic ack;
        logic [7:0] v;
        int c0;
        c0 = commits;
        bus_start();
        send_byte(sel_byte(STRAPS, 1'b0), ack);
        check(ack, "R1", "write select ack", int'(ack), 1);
        send_byte(8'(addr), ack);
        check(ack, "R5", "address ack", int'(ack), 1);
        for (int i = 0; i < n; i++) begin
            v = random_data ? 8'($urandom) : 8'(addr + 3 * i + 1);
            send_byte(v, ack);
            check(ack, "R5", "data ack", int'(ack), 1);
            exp_mem[wrap_addr(addr + i)] = v;
        end
        bus_stop();
        wait_clk(4);
        check(commits == c0 + (n > 0 ? 1 : 0), "R6", "commit pulses", commits - c0,
              n > 0 ? 1 : 0);
        exp_ptr = wrap_addr(addr + n);
    endtask

    task automatic read_body(input int base, input int n, input string req);
        logic [7:0] v;
        for (int i = 0; i < n; i++) begin
            recv_byte(i != n - 1, v);
            check(v == exp_mem[wrap_addr(base + i)], req, "read data", int'(v),
                  int'(exp_mem[wrap_addr(base + i)]));
        end
        exp_ptr = wrap_addr(base + n);
    endtask

    task automatic random_read(input int addr, input int n, input string req);
        logic ack;
        bus_start();
        send_byte(sel_byte(STRAPS, 1'b0), ack);
        send_byte(8'(addr), ack);
        bus_start();
        send_byte(sel_byte(STRAPS, 1'b1), ack);
        check(ack, "R8", "read select ack after restart", int'(ack), 1);
        read_body(wrap_addr(addr), n, req);
        bus_stop();
    endtask

    task automatic current_read(input int n);
        logic ack;
        int base;
        base = exp_ptr;
        bus_start();
        send_byte(sel_byte(STRAPS, 1'b1), ack);
        check(ack, "R7", "current read select ack", int'(ack), 1);
        read_body(base, n, "R7");
        bus_stop();
    endtask

    initial begin
        for (int i = 0; i < 128; i++) exp_mem[i] = 8'h00;
        void'($urandom(32'd4711));
        wait_clk(5);
        check(sda_oe == 1'b0 && wr_en == 1'b0 && rd_en == 1'b0 && wr_commit == 1'b0,
              "R4", "reset outputs", int'({sda_oe, wr_en, rd_en, wr_commit}), 0);
        rst_n = 1'b1;
        wait_clk(5);
        check(sda_oe == 1'b0, "R4", "released after reset", int'(sda_oe), 0);

        // R5 R6: write three bytes at 5, then read them back (R8, R9)
        write_seq(5, 3, 1'b0);
        random_read(5, 3, "R9");
        // R7: current-address read continues at 8
        current_read(2);

        // R9: sequential read across the top of the array
        write_seq(126, 4, 1'b0);
        random_read(126, 4, "R9");

        // R5: bit 7 of the address byte is ignored
        write_seq(8'h80 | 10, 1, 1'b0);
        random_read(10, 1, "R5");

        // R6: address-only write, then STOP gives no commit; pointer set to 40
        write_seq(40, 0, 1'b0);
        current_read(1);

        // R2: wrong straps, no ack, later bytes ignored
        begin
            logic ack;
            int s0;
            s0 = wr_strobes;
            bus_start();
            send_byte(sel_byte(STRAPS ^ 3'b010, 1'b0), ack);
            check(!ack, "R2", "mismatch select ack", int'(ack), 0);
            send_byte(8'd5, ack);
            check(!ack, "R2", "byte after mismatch ack", int'(ack), 0);
            send_byte(8'hEE, ack);
            check(!ack, "R2", "data after mismatch ack", int'(ack), 0);
            bus_stop();
            check(wr_strobes == s0, "R2", "no write strobes", wr_strobes - s0, 0);
            random_read(5, 1, "R2");
        end

        // R11: START while busy is ignored, accepted again once idle
        begin
            logic ack;
            prog_busy = 1'b1;
            bus_start();
            send_byte(sel_byte(STRAPS, 1'b1), ack);
            check(!ack, "R11", "select ack while busy", int'(ack), 0);
            bus_stop();
            prog_busy = 1'b0;
            bus_start();
            send_byte(sel_byte(STRAPS, 1'b1), ack);
            check(ack, "R11", "select ack after busy", int'(ack), 1);
            read_body(exp_ptr, 1, "R11");
            bus_stop();
        end

        // R10: after master NACK the line stays released; STOP then standby
        begin
            logic ack;
            logic [7:0] v;
            bus_start();
            send_byte(sel_byte(STRAPS, 1'b1), ack);
            read_body(exp_ptr, 1, "R10");
            recv_byte(1'b0, v);
            check(v == 8'hFF, "R10", "silent after NACK", int'(v), 255);
            bus_stop();
            random_read(126, 2, "R10");
        end

        // R3: repeated START in the middle of a write restarts select reception
        begin
            logic ack;
            bus_start();
            send_byte(sel_byte(STRAPS, 1'b0), ack);
            send_byte(8'd60, ack);
            bus_start();
            send_byte(sel_byte(STRAPS, 1'b1), ack);
            check(ack, "R3", "select ack after restart", int'(ack), 1);
            read_body(60, 2, "R3");
            bus_stop();
        end

        // Random mix: writes and reads at random addresses
        for (int it = 0; it < 18; it++) begin
            int a, n;
            a = int'($urandom % 128);
            n = 1 + int'($urandom % 4);
            write_seq(a, n, 1'b1);
            if ($urandom % 2 == 0) random_read(a, n, "R9");
            else begin
                random_read(a, 1, "R8");
                current_read(n - 1 > 0 ? n - 1 : 1);
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule